// File: doc/BRIEF.md
# GPS correlator channel

This block is one receiver channel of a spread-spectrum satellite correlator. A 1-bit sampled IF stream arrives one sample per clock over a valid/ready interface. Each accepted sample is first mixed with the sign of a numerically controlled carrier oscillator. The mix is done twice, once with the cosine and once with the sine, which gives an in-phase arm and a quadrature arm. Each arm is then multiplied by a locally generated replica spreading code at three offsets (early, prompt and late), spaced half a chip apart.

Four signed sums are kept:
- in-phase prompt,
- quadrature prompt,
- in-phase early-minus-late,
- quadrature early-minus-late.

At the end of every 1023-chip code epoch, the four sums are copied into holding outputs and the running sums restart from zero. A sticky interrupt then tells the host that fresh results are ready, and the host acknowledges with a one-cycle pulse.

The replica code comes from a pair of 10-stage shift registers. Two input fields select the code: a pair of tap positions and the starting state of the second register. The tap pair picks any navigation Gold code, and with a non-default start state the same generator produces augmentation-system codes.

A self-test output drives the prompt code, mixed with a quarter-rate square wave and the carrier cosine sign. Its signal can be fed back into the input path.

The input stream is never back-pressured: `s_ready` is low only while reset is held. An upstream source may therefore present a sample in any cycle outside reset, and a cycle with `s_valid` low simply leaves the channel state untouched.

Top module: `gps_corr_channel`

## Requirements
- R1: While `rst` is high, `s_ready`, `irq` and `st_out` are 0 and all four result outputs are 0. Once reset is released, `irq` stays 0 until the first epoch.
- R2: A sample is taken only in a cycle with `s_valid` and `s_ready` both high, and `s_ready` equals the inverse of `rst`. A cycle without a taken sample changes neither the code state, the carrier state nor the running sums.
- R3: The carrier phase is 24 bits wide and is reset to 0. It advances by `nco_incr` on each taken sample, and its top two bits give the quadrant q used for that sample. The cosine sign is negative for q = 1 and q = 2. The sine sign is negative for q = 2 and q = 3. The magnitude is 1. A sample bit of 1 stands for +1 and 0 stands for -1.
- R4: The code generator has two 10-stage registers, with stage 1 as the input and stage 10 as the output. The first register feeds back stages 3 and 10; the second feeds back stages 2, 3, 6, 8, 9 and 10. The code bit is the XOR of first-register stage 10 with second-register stages `tap_a` and `tap_b`, where a code bit of 1 means -1. At reset, at restart and at each epoch, the first register is loaded with all ones and the second with `g2_init`.
- R5: The code phase is 16 bits wide and is reset to 0. It advances by `code_incr` on each taken sample, and a carry out of the phase marks a half-chip tick. Every second tick, starting with the second after a reset or restart, shifts both registers by one chip. An epoch is 1023 chips long.
- R6: A 3-stage line of code bits shifts on every half-chip tick. It takes the current code bit in as its early tap; the middle stage is prompt and the oldest stage is late. All three stages are 0 after reset or restart.
- R7: For each taken sample, the prompt contribution on each arm is the product of the sample, that arm's carrier sign and the prompt code. The early-minus-late contribution is the same product with early minus the same product with late. The in-phase arms use the cosine sign and the quadrature arms use the sine sign.
- R8: The running sums are 16-bit signed and saturate at 32767 and -32768 instead of wrapping.
- R9: The epoch sample is the taken sample whose chip advance moves the chip count from 1022 to 0. On it, the holding outputs load the sums including that sample's contribution, the running sums clear to 0, and `irq` is set. The holding outputs change at no other time.
- R10: `irq` stays set until a cycle with `rd_ack` high, after which it is 0. If an epoch falls in the same cycle as the acknowledge, `irq` stays set.
- R11: With `selftest` high, `st_out` is the XOR of the prompt code bit, bit 1 of a two-bit counter and the cosine negative flag. The counter is reset to 0 and then counts every clock. With `selftest` low, `st_out` is 0.
- R12: A `restart` cycle returns the code phase, code registers, delay line, carrier phase and running sums to their reset values. It discards any sample offered in that cycle, and it leaves the holding outputs and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample present |
| s_data | input | 1 | 1-bit IF sample (1 = +1) |
| s_ready | output | 1 | Channel can take a sample |
| nco_incr | input | 24 | Carrier phase step per sample |
| code_incr | input | 16 | Code phase step per sample (carry = half chip) |
| tap_a | input | 4 | First second-register tap (1..10) |
| tap_b | input | 4 | Second second-register tap (1..10) |
| g2_init | input | 10 | Second-register start state |
| restart | input | 1 | Synchronous channel restart |
| selftest | input | 1 | Enable self-test output |
| rd_ack | input | 1 | Host acknowledge of results |
| irq | output | 1 | Sticky results-ready flag |
| ip | output | 16 | In-phase prompt sum |
| qp | output | 16 | Quadrature prompt sum |
| iel | output | 16 | In-phase early-minus-late sum |
| qel | output | 16 | Quadrature early-minus-late sum |
| st_out | output | 1 | Self-test signal |

## Verification
The assertions assume that `tap_a` and `tap_b` stay within 1 to 10, that `g2_init` is non-zero, and that the code selection and both phase steps are changed only together with a `restart`. They also assume that `rd_ack` is pulsed only while `irq` is set. The stimulus sets every control field before asserting `restart`, keeps it fixed for the whole of each phase, and issues `rd_ack` as a single pulse only after it has observed `irq`. The valid pattern and the sample values vary freely, because the block has to accept any combination of the two.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic [1:0] {
    ARM_IP  = 2'd0,
    ARM_QP  = 2'd1,
    ARM_IEL = 2'd2,
    ARM_QEL = 2'd3
  } arm_e;

  localparam int NARMS = 4;
endpackage

// File: rtl/corr_code_gen.sv
module corr_code_gen #(
  parameter int CPW      = 16,
  parameter int LFSR_W   = 10,
  parameter int CODE_LEN = 1023,
  parameter logic [LFSR_W-1:0] G1_MASK = 10'h204,
  parameter logic [LFSR_W-1:0] G2_MASK = 10'h3A6,
  localparam int CNT_W = $clog2(CODE_LEN),
  localparam int TAP_W = $clog2(LFSR_W + 1),
  localparam int DL_N  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              take,
  input  logic [CPW-1:0]    code_incr,
  input  logic [TAP_W-1:0]  tap_a,
  input  logic [TAP_W-1:0]  tap_b,
  input  logic [LFSR_W-1:0] g2_init,
  output logic              early,
  output logic              prompt,
  output logic              late,
  output logic              epoch
);
  logic [CPW-1:0]    cph;
  logic [CPW:0]      cph_sum;
  logic              half;
  logic [LFSR_W-1:0] g1, g2;
  logic [CNT_W-1:0]  cnt;
  logic [DL_N-1:0]   dl;
  logic              hc, chip_adv, code_bit, fb1, fb2;

  assign cph_sum  = {1'b0, cph} + {1'b0, code_incr};
  assign hc       = take & cph_sum[CPW];
  assign chip_adv = hc & half;
  assign epoch    = chip_adv & (cnt == CNT_W'(CODE_LEN - 1));
  assign fb1      = ^(g1 & G1_MASK);
  assign fb2      = ^(g2 & G2_MASK);
  assign code_bit = g1[LFSR_W-1] ^ g2[tap_a - TAP_W'(1)] ^ g2[tap_b - TAP_W'(1)];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cph  <= '0;
      half <= 1'b0;
      g1   <= '1;
      g2   <= g2_init;
      cnt  <= '0;
      dl   <= '0;
    end else if (take) begin
      cph <= cph_sum[CPW-1:0];
      if (hc) begin
        dl   <= {dl[DL_N-2:0], code_bit};
        half <= ~half;
      end
      if (chip_adv) begin
        if (epoch) begin
          cnt <= '0;
          g1  <= '1;
          g2  <= g2_init;
        end else begin
          cnt <= cnt + CNT_W'(1);
          g1  <= {g1[LFSR_W-2:0], fb1};
          g2  <= {g2[LFSR_W-2:0], fb2};
        end
      end
    end
  end

  assign early  = dl[0];
  assign prompt = dl[1];
  assign late   = dl[2];
endmodule

// File: rtl/corr_carrier_nco.sv
module corr_carrier_nco #(
  parameter int PH_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            take,
  input  logic [PH_W-1:0] incr,
  output logic            cos_neg,
  output logic            sin_neg
);
  logic [PH_W-1:0] ph;
  logic [1:0]      quad;

  always_ff @(posedge clk) begin
    if (rst || restart) ph <= '0;
    else if (take)      ph <= ph + incr;
  end

  assign quad = ph[PH_W-1:PH_W-2];

  // sign table, quadrant centres at 45, 135, 225 and 315 degrees
  always_comb begin
    unique case (quad)
      2'd0:    begin cos_neg = 1'b0; sin_neg = 1'b0; end
      2'd1:    begin cos_neg = 1'b1; sin_neg = 1'b0; end
      2'd2:    begin cos_neg = 1'b1; sin_neg = 1'b1; end
      default: begin cos_neg = 1'b0; sin_neg = 1'b1; end
    endcase
  end
endmodule

// File: rtl/corr_accum.sv
module corr_accum import corr_pkg::*; #(
  parameter int ACC_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic                        take,
  input  logic                        epoch,
  input  logic                        rd_ack,
  input  logic [NARMS-1:0][ACC_W-1:0] contrib,
  output logic [NARMS-1:0][ACC_W-1:0] acc,
  output logic [NARMS-1:0][ACC_W-1:0] hold,
  output logic                        ready
);
  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  for (genvar a = 0; a < NARMS; a++) begin : g_arm
    logic [ACC_W:0]   ext;
    logic [ACC_W-1:0] nxt, acc_r, hold_r;

    assign ext = {acc_r[ACC_W-1], acc_r} + {contrib[a][ACC_W-1], contrib[a]};

    always_comb begin
      if (ext[ACC_W] != ext[ACC_W-1]) nxt = ext[ACC_W] ? MINV : MAXV;
      else                            nxt = ext[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst || restart) acc_r <= '0;
      else if (take)      acc_r <= epoch ? '0 : nxt;
    end

    always_ff @(posedge clk) begin
      if (rst)        hold_r <= '0;
      else if (epoch) hold_r <= nxt;
    end

    assign acc[a]  = acc_r;
    assign hold[a] = hold_r;
  end

  always_ff @(posedge clk) begin
    if (rst)         ready <= 1'b0;
    else if (epoch)  ready <= 1'b1;
    else if (rd_ack) ready <= 1'b0;
  end
endmodule

// File: rtl/gps_corr_channel.sv
module gps_corr_channel import corr_pkg::*; #(
  parameter int PH_W     = 24,
  parameter int CPW      = 16,
  parameter int ACC_W    = 16,
  parameter int MAG      = 1,
  parameter int LFSR_W   = 10,
  parameter int CODE_LEN = 1023,
  localparam int TAP_W   = $clog2(LFSR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_data,
  output logic              s_ready,
  input  logic [PH_W-1:0]   nco_incr,
  input  logic [CPW-1:0]    code_incr,
  input  logic [TAP_W-1:0]  tap_a,
  input  logic [TAP_W-1:0]  tap_b,
  input  logic [LFSR_W-1:0] g2_init,
  input  logic              restart,
  input  logic              selftest,
  input  logic              rd_ack,
  output logic              irq,
  output logic [ACC_W-1:0]  ip,
  output logic [ACC_W-1:0]  qp,
  output logic [ACC_W-1:0]  iel,
  output logic [ACC_W-1:0]  qel,
  output logic              st_out
);
  logic take, early, prompt, late, epoch, cos_neg, sin_neg, s_neg;
  logic [1:0] fs4;
  logic [NARMS-1:0][ACC_W-1:0] contrib, acc, hold;

  assign s_ready = ~rst;
  assign take    = s_valid & s_ready & ~restart;
  assign s_neg   = ~s_data;

  function automatic logic [ACC_W-1:0] pv(input logic neg);
    logic [ACC_W-1:0] m;
    m = ACC_W'(MAG);
    return neg ? (~m + ACC_W'(1)) : m;
  endfunction

  assign contrib[ARM_IP]  = pv(s_neg ^ cos_neg ^ prompt);
  assign contrib[ARM_QP]  = pv(s_neg ^ sin_neg ^ prompt);
  assign contrib[ARM_IEL] = pv(s_neg ^ cos_neg ^ early) - pv(s_neg ^ cos_neg ^ late);
  assign contrib[ARM_QEL] = pv(s_neg ^ sin_neg ^ early) - pv(s_neg ^ sin_neg ^ late);

  corr_code_gen #(.CPW(CPW), .LFSR_W(LFSR_W), .CODE_LEN(CODE_LEN)) u_code (
    .clk(clk), .rst(rst), .restart(restart), .take(take), .code_incr(code_incr),
    .tap_a(tap_a), .tap_b(tap_b), .g2_init(g2_init),
    .early(early), .prompt(prompt), .late(late), .epoch(epoch)
  );

  corr_carrier_nco #(.PH_W(PH_W)) u_nco (
    .clk(clk), .rst(rst), .restart(restart), .take(take), .incr(nco_incr),
    .cos_neg(cos_neg), .sin_neg(sin_neg)
  );

  corr_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .restart(restart), .take(take), .epoch(epoch),
    .rd_ack(rd_ack), .contrib(contrib), .acc(acc), .hold(hold), .ready(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) fs4 <= '0;
    else     fs4 <= fs4 + 2'd1;
  end

  assign st_out = selftest & (prompt ^ fs4[1] ^ cos_neg);
  assign ip  = hold[ARM_IP];
  assign qp  = hold[ARM_QP];
  assign iel = hold[ARM_IEL];
  assign qel = hold[ARM_QEL];
endmodule

// File: rtl/corr_channel_checker.sv
module corr_channel_checker import corr_pkg::*; #(
  parameter int ACC_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        restart,
  input logic                        take,
  input logic                        epoch,
  input logic                        rd_ack,
  input logic                        irq,
  input logic [NARMS-1:0][ACC_W-1:0] acc,
  input logic [NARMS-1:0][ACC_W-1:0] hold
);
  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  AST_IDLE_KEEPS_SUMS: assert property (@(posedge clk) disable iff (rst)
    (!take && !restart) |=> $stable(acc)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (acc[0] == MAXV && !epoch && !restart) |=> (acc[0] != MINV)); // R8

  AST_HOLD_ONLY_AT_EPOCH: assert property (@(posedge clk) disable iff (rst)
    !epoch |=> $stable(hold)); // R9

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    epoch |=> irq); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !epoch) |=> !irq); // R10

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (acc == '0)); // R12
endmodule

bind gps_corr_channel corr_channel_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .take(take), .epoch(epoch),
  .rd_ack(rd_ack), .irq(irq), .acc(acc), .hold(hold)
);

// File: tb/gps_corr_channel_bench.sv
module gps_corr_channel_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_data = 1'b0, restart = 1'b0, selftest = 1'b0, rd_ack = 1'b0;
  logic [23:0] nco_incr = '0;
  logic [15:0] code_incr = '0;
  logic [3:0]  tap_a = 4'd2, tap_b = 4'd6;
  logic [9:0]  g2_init = 10'h3FF;
  logic s_ready, irq, st_out;
  logic [15:0] ip, qp, iel, qel;

  always #2 clk = ~clk;

  gps_corr_channel u_gps_corr_channel (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .nco_incr(nco_incr), .code_incr(code_incr), .tap_a(tap_a), .tap_b(tap_b),
    .g2_init(g2_init), .restart(restart), .selftest(selftest), .rd_ack(rd_ack),
    .irq(irq), .ip(ip), .qp(qp), .iel(iel), .qel(qel), .st_out(st_out)
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  logic [15:0] m_cph;
  logic        m_half;
  logic [9:0]  m_g1, m_g2;
  int          m_cnt;
  logic [2:0]  m_dl;
  logic [23:0] m_ph;
  int          m_acc[4];
  logic [1:0]  m_fs4;
  int          m_ep;

  function automatic bit cneg(input logic [23:0] p); return p[23] ^ p[22]; endfunction
  function automatic bit sneg(input logic [23:0] p); return p[23]; endfunction
  function automatic int pv(input bit n); return n ? -1 : 1; endfunction
  function automatic int sat(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic m_clear();
    m_cph = '0; m_half = 0; m_g1 = '1; m_g2 = g2_init; m_cnt = 0; m_dl = '0; m_ph = '0;
    for (int i = 0; i < 4; i++) m_acc[i] = 0;
  endtask

  // one cycle: check state, drive inputs, advance model; mode 0 random data, 1 matched
  task automatic step(input bit v, input int mode, input bit rs);
    bit d, sn, cn, qn, cb, hc, ep;
    logic [16:0] s;
    logic [63:0] item;
    int c[4];
    if (selftest) chk(st_out == (m_dl[1] ^ m_fs4[1] ^ cneg(m_ph)), "R11 self-test",
                      st_out, m_dl[1] ^ m_fs4[1] ^ cneg(m_ph));
    cn = cneg(m_ph); qn = sneg(m_ph);
    d = (mode == 1) ? ~(cn ^ m_dl[1]) : 1'($urandom_range(1));
    s_valid = v; s_data = d; restart = rs;
    m_fs4 = m_fs4 + 2'd1;
    if (rs) m_clear();
    else if (v) begin
      sn = ~d;
      c[0] = pv(sn ^ cn ^ m_dl[1]);
      c[1] = pv(sn ^ qn ^ m_dl[1]);
      c[2] = pv(sn ^ cn ^ m_dl[0]) - pv(sn ^ cn ^ m_dl[2]);
      c[3] = pv(sn ^ qn ^ m_dl[0]) - pv(sn ^ qn ^ m_dl[2]);
      for (int i = 0; i < 4; i++) m_acc[i] = sat(m_acc[i] + c[i]);
      s = {1'b0, m_cph} + {1'b0, code_incr};
      hc = s[16];
      ep = hc && m_half && (m_cnt == 1022);
      cb = m_g1[9] ^ m_g2[tap_a - 1] ^ m_g2[tap_b - 1];
      m_cph = s[15:0];
      m_ph = m_ph + nco_incr;
      if (hc) begin
        m_dl = {m_dl[1:0], cb};
        if (m_half) begin
          if (ep) begin m_cnt = 0; m_g1 = '1; m_g2 = g2_init; end
          else begin
            m_cnt++;
            m_g1 = {m_g1[8:0], m_g1[2] ^ m_g1[9]};
            m_g2 = {m_g2[8:0], m_g2[1] ^ m_g2[2] ^ m_g2[5] ^ m_g2[7] ^ m_g2[8] ^ m_g2[9]};
          end
        end
        m_half = ~m_half;
      end
      if (ep) begin
        item = {16'(m_acc[0]), 16'(m_acc[1]), 16'(m_acc[2]), 16'(m_acc[3])};
        exp_q.push_back(item);
        for (int i = 0; i < 4; i++) m_acc[i] = 0;
        m_ep++;
      end
    end
    @(negedge clk);
  endtask

  // monitor: compares each dump against the scoreboard
  initial begin
    logic [63:0] e;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        chk(irq == 1'b0, "R10 irq cleared by ack", irq, 0);
      end else if (!rst && irq) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected dump", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(ip  == e[63:48], "R7 R3 R4 ip dump",  $signed(ip),  $signed(e[63:48]));
          chk(qp  == e[47:32], "R7 R3 qp dump",     $signed(qp),  $signed(e[47:32]));
          chk(iel == e[31:16], "R6 R5 iel dump",    $signed(iel), $signed(e[31:16]));
          chk(qel == e[15:0],  "R6 R2 qel dump",    $signed(qel), $signed(e[15:0]));
        end
        rd_ack = 1'b1;
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic run_phase(input int epochs, input bit full, input int mode);
    int target;
    target = m_ep + epochs;
    while (m_ep < target) step(full ? 1'b1 : ($urandom_range(3) != 0), mode, 1'b0);
  endtask

  initial begin
    logic [15:0] keep;
    m_clear(); m_fs4 = '0; m_ep = 0;
    repeat (3) begin
      @(negedge clk);
      chk(s_ready == 0 && irq == 0 && st_out == 0, "R1 outputs in reset", {s_ready, irq, st_out}, 0);
      chk(ip == 0 && qp == 0 && iel == 0 && qel == 0, "R1 results in reset", ip | qp | iel | qel, 0);
    end
    nco_incr = 24'h123457; code_incr = 16'h8000; selftest = 1'b1;
    rst = 1'b0;
    step(1'b0, 0, 1'b0);
    chk(s_ready == 1 && irq == 0, "R1 R2 after reset", {s_ready, irq}, 2);
    // phase 0: navigation code, irregular valid pattern
    run_phase(2, 0, 0);
    // phase 1: augmentation-style start state, other taps and steps
    tap_a = 4'd3; tap_b = 4'd7; g2_init = 10'h0D5; nco_incr = 24'hFFF000;
    code_incr = 16'hC000; selftest = 1'b0;
    keep = ip;
    step(1'b1, 0, 1'b1);
    chk(ip == keep, "R12 restart keeps holding", ip, keep);
    run_phase(2, 0, 0);
    // phase 2: matched data, every prompt product positive
    nco_incr = '0; code_incr = 16'h2000;
    step(1'b1, 0, 1'b1);
    run_phase(1, 1, 1);
    repeat (4) step(1'b0, 0, 1'b0);
    chk(ip == 16'd16368, "R7 matched prompt sum", ip, 16368);
    chk(qp == 16'd16368, "R3 matched quadrature sum", qp, 16368);
    // phase 3: long epoch drives the sum past the limit
    code_incr = 16'h0800;
    step(1'b1, 0, 1'b1);
    run_phase(1, 1, 1);
    repeat (4) step(1'b0, 0, 1'b0);
    chk(ip == 16'd32767, "R8 positive saturation", ip, 32767);
    chk(exp_q.size() == 0, "R9 all dumps seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule